// File: doc/BRIEF.md
# Stepped Transmit Level Controller

This block is the digital half of a transmit level loop. A free-running control period, derived from the system clock, is split into two phases. The first is a settling phase, in which the variable-gain amplifier is given time to reach its new setting. The second is a detect phase, in which two analog peak comparators are watched. One comparator reports that the feedback amplitude rose above a low threshold. The other reports that it rose above a high threshold.

At the close of every period, the block moves a 5-bit attenuation index by at most one step, or leaves it alone. Index 0 is the full-gain setting (0 dB). Index 31 is the deepest attenuation (-26 dB), and each step is about 0.84 dB. With the default 1536-clock period at 11.0592 MHz, the index is updated 7200 times per second. The settling phase is 384 clocks and the detect phase is 1152 clocks.

The index and a phase flag are the only outputs. The comparators and the amplifier are outside the block. Deasserting the transmit-enable input parks the loop at the deepest attenuation and restarts the period at its settling phase.

Top module: `alc_stepper`

## Requirements
- R1: While `rstN` is low, and on the clock edge after `txActive` is sampled low, `gainIdx` is 31 and `detectPhase` is 0. When `txActive` returns high, the period restarts from its first settling clock.
- R2: While `txActive` is high, the period is SETTLE_CLKS+DETECT_CLKS clocks. `detectPhase` reads 0 for the first SETTLE_CLKS clocks and 1 for the remaining DETECT_CLKS clocks, and then the next period begins.
- R3: If neither comparator flag is seen during a detect phase, `gainIdx` decreases by one (gain raised one step) at the period end.
- R4: If `overHigh` is seen during a detect phase, `gainIdx` increases by one (gain lowered one step) at the period end.
- R5: If only `overLow` is seen during a detect phase, `gainIdx` is unchanged at the period end.
- R6: If both flags are seen in the same detect phase, the increase wins.
- R7: Flag activity that reaches the synchronizer output during the settling phase has no effect on `gainIdx`.
- R8: A flag high for a single clock inside the detect phase is held until the period end and counts for that period.
- R9: `gainIdx` saturates at 0 and at 31 and never wraps. It changes only at a period end or through R1.
- R10: Both flags pass through a two-flop synchronizer. A flag sampled on the final clock edge of a period lands in the next settling phase, and so it is ignored.
- R11: A sweep from 31 down to 0, or from 0 up to 31, takes exactly 31 periods. With the default parameters this is 47616 clocks, about 4.3 ms, which is inside the 5 ms settling budget.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| txActive | input | 1 | High while transmitting; low parks and restarts the loop |
| overLow | input | 1 | Asynchronous comparator flag: feedback peak above the low threshold |
| overHigh | input | 1 | Asynchronous comparator flag: feedback peak above the high threshold |
| gainIdx | output | 5 | Attenuation index, 0 = 0 dB, 31 = -26 dB |
| detectPhase | output | 1 | 1 during the detect phase, 0 during settling |

## Verification
The bench builds the block with SETTLE_CLKS=4 and DETECT_CLKS=8, which gives a 12-clock period. With so short a period, full sweeps in both directions, saturation held over several periods, and restarts in the middle of a period all fit in under a thousand clocks. The short settling phase also makes the synchronizer delay matter. A pulse on the last clock of a period then lands inside the next settling phase, and a pulse on the first settling clock reaches the logic while settling is still under way. Together these exercise the window-edge cases of R7 and R10.

// File: rtl/alc_pkg.sv
package alc_pkg;
  typedef struct packed {
    logic restart;
    logic detectEn;
    logic periodEnd;
  } alcStrobe_t;
endpackage

// File: rtl/alc_sequencer.sv
module alc_sequencer
  import alc_pkg::*;
#(
  parameter int SETTLE_CLKS = 384,
  parameter int DETECT_CLKS = 1152
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       txActive,
  output alcStrobe_t strobes,
  output logic       detectPhase
);
  localparam int PERIOD = SETTLE_CLKS + DETECT_CLKS;
  localparam int CNT_W  = $clog2(PERIOD);
  localparam logic [CNT_W-1:0] LAST_CNT   = CNT_W'(PERIOD - 1);
  localparam logic [CNT_W-1:0] SETTLE_END = CNT_W'(SETTLE_CLKS);

  logic [CNT_W-1:0] phaseCnt;
  logic             atLast;

  assign atLast = (phaseCnt == LAST_CNT);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      phaseCnt <= '0;
    else if (!txActive || atLast)
      phaseCnt <= '0;
    else
      phaseCnt <= phaseCnt + 1'b1;
  end

  assign detectPhase       = (phaseCnt >= SETTLE_END);
  assign strobes.restart   = !txActive;
  assign strobes.detectEn  = txActive && detectPhase;
  assign strobes.periodEnd = txActive && atLast;
endmodule

// File: rtl/alc_datapath.sv
module alc_datapath
  import alc_pkg::*;
#(
  parameter int IDX_W       = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             overLow,
  input  logic             overHigh,
  input  alcStrobe_t       strobes,
  output logic [IDX_W-1:0] gainIdx
);
  localparam logic [IDX_W-1:0] IDX_MAX = {IDX_W{1'b1}};
  localparam logic [IDX_W-1:0] IDX_MIN = '0;

  logic [SYNC_STAGES-1:0] lowSync;
  logic [SYNC_STAGES-1:0] highSync;

  for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          lowSync[0]  <= 1'b0;
          highSync[0] <= 1'b0;
        end else begin
          lowSync[0]  <= overLow;
          highSync[0] <= overHigh;
        end
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          lowSync[i]  <= 1'b0;
          highSync[i] <= 1'b0;
        end else begin
          lowSync[i]  <= lowSync[i-1];
          highSync[i] <= highSync[i-1];
        end
      end
    end
  end

  logic sawLow, sawHigh;
  logic lowNow, highNow;

  assign lowNow  = sawLow  || (strobes.detectEn && lowSync[SYNC_STAGES-1]);
  assign highNow = sawHigh || (strobes.detectEn && highSync[SYNC_STAGES-1]);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sawLow  <= 1'b0;
      sawHigh <= 1'b0;
    end else if (strobes.restart || strobes.periodEnd) begin
      sawLow  <= 1'b0;
      sawHigh <= 1'b0;
    end else begin
      sawLow  <= lowNow;
      sawHigh <= highNow;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      gainIdx <= IDX_MAX;
    else if (strobes.restart)
      gainIdx <= IDX_MAX;
    else if (strobes.periodEnd) begin
      if (highNow) begin
        if (gainIdx != IDX_MAX) gainIdx <= gainIdx + 1'b1;
      end else if (!lowNow) begin
        if (gainIdx != IDX_MIN) gainIdx <= gainIdx - 1'b1;
      end
    end
  end
endmodule

// File: rtl/alc_stepper.sv
module alc_stepper
  import alc_pkg::*;
#(
  parameter int SETTLE_CLKS = 384,
  parameter int DETECT_CLKS = 1152,
  parameter int IDX_W       = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             txActive,
  input  logic             overLow,
  input  logic             overHigh,
  output logic [IDX_W-1:0] gainIdx,
  output logic             detectPhase
);
  alcStrobe_t strobes;

  alc_sequencer #(
    .SETTLE_CLKS(SETTLE_CLKS),
    .DETECT_CLKS(DETECT_CLKS)
  ) u_seq (
    .clk        (clk),
    .rstN       (rstN),
    .txActive   (txActive),
    .strobes    (strobes),
    .detectPhase(detectPhase)
  );

  alc_datapath #(
    .IDX_W      (IDX_W),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .overLow (overLow),
    .overHigh(overHigh),
    .strobes (strobes),
    .gainIdx (gainIdx)
  );
endmodule

// File: rtl/alc_stepper_chk.sv
module alc_stepper_chk #(
  parameter int IDX_W = 5
) (
  input logic             clk,
  input logic             rstN,
  input logic             txActive,
  input logic             periodEnd,
  input logic [IDX_W-1:0] gainIdx,
  input logic             detectPhase
);
  localparam logic [IDX_W-1:0] IDX_MAX = {IDX_W{1'b1}};

  // R1
  idx_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    !txActive |=> (gainIdx == IDX_MAX && !detectPhase));

  // R9
  idx_boundary_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(gainIdx) |-> ($past(periodEnd) || !$past(txActive)));

  // R9
  idx_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(txActive) && $past(periodEnd)) |->
      ((int'(gainIdx) - int'($past(gainIdx)) == 0) ||
       (int'(gainIdx) - int'($past(gainIdx)) == 1) ||
       (int'(gainIdx) - int'($past(gainIdx)) == -1)));

  // R2
  phase_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(detectPhase) |-> ($past(periodEnd) || !$past(txActive)));
endmodule

bind alc_stepper alc_stepper_chk #(.IDX_W(IDX_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .txActive   (txActive),
  .periodEnd  (strobes.periodEnd),
  .gainIdx    (gainIdx),
  .detectPhase(detectPhase)
);

// File: tb/sim_alc_stepper.sv
`timescale 1ns/1ps
module sim_alc_stepper;
  localparam int S = 4;
  localparam int D = 8;
  localparam int P = S + D;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic txActive = 1'b0;
  logic overLow = 1'b0;
  logic overHigh = 1'b0;
  logic [4:0] gainIdx;
  logic detectPhase;

  int nChecks = 0;
  int nErr = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  alc_stepper #(.SETTLE_CLKS(S), .DETECT_CLKS(D), .IDX_W(5), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rstN(rstN), .txActive(txActive), .overLow(overLow),
    .overHigh(overHigh), .gainIdx(gainIdx), .detectPhase(detectPhase)
  );

  task automatic check(string req, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nErr++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Behavioural reference: period position, index, held flags, flag history.
  int mCnt = 0;
  int mIdx = 31;
  bit mSawL = 0, mSawH = 0;
  bit histL[2] = '{0, 0};
  bit histH[2] = '{0, 0};

  always @(posedge clk) begin
    bit sL, sH, dEn, lNow, hNow;
    if (!rstN) begin
      mCnt = 0; mIdx = 31; mSawL = 0; mSawH = 0;
      histL = '{0, 0}; histH = '{0, 0};
    end else begin
      sL = histL[1];
      sH = histH[1];
      if (!txActive) begin
        mCnt = 0; mIdx = 31; mSawL = 0; mSawH = 0;
      end else begin
        dEn  = (mCnt >= S);
        lNow = mSawL | (dEn & sL);
        hNow = mSawH | (dEn & sH);
        if (mCnt == P - 1) begin
          if (hNow) begin
            if (mIdx < 31) mIdx++;
          end else if (!lNow) begin
            if (mIdx > 0) mIdx--;
          end
          mSawL = 0; mSawH = 0; mCnt = 0;
        end else begin
          mSawL = lNow; mSawH = hNow; mCnt++;
        end
      end
      histL[1] = histL[0]; histL[0] = overLow;
      histH[1] = histH[0]; histH[0] = overHigh;
    end
  end

  always @(negedge clk) begin
    if (rstN && !done) begin
      check("R2 model index", int'(gainIdx), mIdx);
      check("R2 model phase", int'(detectPhase), (mCnt >= S) ? 1 : 0);
    end
  end

  task automatic waitEdges(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finishRun();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nErr++;
    $display("FAIL watchdog: actual=expired expected=finished");
    finishRun();
  end

  initial begin
    int sweep;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset index", int'(gainIdx), 31);
    check("R1 reset phase", int'(detectPhase), 0);
    rstN = 1'b1;
    waitEdges(2);
    check("R1 idle index", int'(gainIdx), 31);
    txActive = 1'b1;
    waitEdges(S - 1);
    check("R2 last settle clock", int'(detectPhase), 0);
    waitEdges(1);
    check("R2 first detect clock", int'(detectPhase), 1);
    waitEdges(D - 1);
    check("R2 index before period end", int'(gainIdx), 31);
    waitEdges(1);
    check("R3 quiet period lowers index", int'(gainIdx), 30);
    check("R2 new period settles", int'(detectPhase), 0);
    waitEdges(5 * P);
    check("R3 five quiet periods", int'(gainIdx), 25);

    overLow = 1'b1;
    waitEdges(P);
    check("R5 low only holds", int'(gainIdx), 25);
    overHigh = 1'b1;
    waitEdges(P);
    check("R6 both flags raise index", int'(gainIdx), 26);
    overLow = 1'b0;
    waitEdges(P);
    check("R4 high raises index", int'(gainIdx), 27);
    overHigh = 1'b0;
    waitEdges(P);
    check("R7 flag cleared during settle", int'(gainIdx), 26);

    overLow = 1'b1;
    waitEdges(1);
    overLow = 1'b0;
    waitEdges(P - 1);
    check("R7 settle pulse ignored", int'(gainIdx), 25);

    waitEdges(6);
    overLow = 1'b1;
    waitEdges(1);
    overLow = 1'b0;
    waitEdges(P - 7);
    check("R8 one-clock low pulse held", int'(gainIdx), 25);
    waitEdges(7);
    overHigh = 1'b1;
    waitEdges(1);
    overHigh = 1'b0;
    waitEdges(P - 8);
    check("R8 one-clock high pulse held", int'(gainIdx), 26);

    waitEdges(P - 1);
    overHigh = 1'b1;
    waitEdges(1);
    overHigh = 1'b0;
    check("R10 last-edge pulse not counted", int'(gainIdx), 25);
    waitEdges(P);
    check("R10 pulse does not leak into next period", int'(gainIdx), 24);

    waitEdges(24 * P);
    check("R9 reaches zero", int'(gainIdx), 0);
    waitEdges(3 * P);
    check("R9 saturates at zero", int'(gainIdx), 0);

    overHigh = 1'b1;
    sweep = 0;
    for (int k = 0; k < 40; k++) begin
      if (gainIdx == 5'd31) break;
      waitEdges(P);
      sweep++;
    end
    check("R11 upward sweep periods", sweep, 31);
    waitEdges(3 * P);
    check("R9 saturates at 31", int'(gainIdx), 31);

    overHigh = 1'b0;
    waitEdges(3 * P);
    check("R3 descent after saturation", int'(gainIdx), 28);
    waitEdges(5);
    txActive = 1'b0;
    waitEdges(1);
    check("R1 tx drop index", int'(gainIdx), 31);
    check("R1 tx drop phase", int'(detectPhase), 0);
    waitEdges(3);
    txActive = 1'b1;
    waitEdges(S);
    check("R1 restart at settle start", int'(detectPhase), 1);
    waitEdges(D);
    check("R1 first period after restart", int'(gainIdx), 30);

    rstN = 1'b0;
    waitEdges(1);
    check("R1 mid-run reset index", int'(gainIdx), 31);
    check("R1 mid-run reset phase", int'(detectPhase), 0);
    finishRun();
  end
endmodule